// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets a host controller read and write a small file of control, status and trim registers over a four-wire serial link. A transfer begins when the active-low select falls and ends when it rises. During a complete transfer the host clocks in two bytes: a command byte and a data byte. While the command byte comes in, the slave clocks out a global status byte. While the data byte comes in, it clocks out the addressed register.

All serial inputs are synchronised into the system clock domain and their edges are detected there. The serial clock must therefore run well below the system clock. The bench uses a ratio of 16 system clocks per serial clock. A write takes effect only when select rises, and only if three conditions all hold: exactly sixteen serial clock rising edges occurred, the command is a write, and the command parity is odd. The registers drive the analog functions behind them through `ctrl_q`. Their read-only status bits arrive on `stat_in`.

A frame-level state machine tracks each transfer through five states:

| State | Meaning |
|---|---|
| S_IDLE | Select is high. |
| S_CMD | The command byte is arriving. |
| S_DATA | The data byte is arriving. |
| S_FULL | Exactly sixteen edges have been seen. |
| S_OVER | More than sixteen edges have been seen. |

It moves between them as follows:

| From | To | Condition |
|---|---|---|
| S_IDLE | S_CMD | Select falls. |
| S_CMD | S_DATA | Eighth rising edge. |
| S_DATA | S_FULL | Sixteenth rising edge. |
| S_FULL | S_OVER | Any further rising edge. |
| Any other state | S_IDLE | Select rises. |

The write commit happens only on the S_FULL to S_IDLE transition.

Top module: `spi_reg_slave`

## Requirements
- R1: The interface uses SPI mode 0 and sends the MSB first. The host samples data on a rising edge of the serial clock and the slave changes its output after a falling edge. The command byte has the address in bits [7:3], an unused bit 2, the read/write flag in bit 1 (1 = read, 0 = write) and the parity bit in bit 0.
- R2: In every frame, whether read or write, the first reply byte is the readback of the status register at address 0x0C.
- R3: The second reply byte is the readback of the addressed register. On a write frame this is the value before the write.
- R4: Register contents change only when select rises. `ctrl_q` is unchanged until then.
- R5: A write is committed only if the XOR of command bits [7:3], [1] and [0] equals 1 (odd parity). A write with bad parity is dropped silently, and its reply bytes are still sent. Parity has no effect on reads.
- R6: A frame with any number of rising serial clock edges other than 16 updates no register.
- R7: Addresses 0x0F, 0x10 and 0x11 are write-only. They store all 8 bits, appear on `ctrl_q`, and read back as 0x00.
- R8: Address 0x0E never accepts a write and reads back 0x00. Addresses 0x12 to 0x1F read back 0x00 and ignore writes.
- R9: Each register has a writable mask W and a status mask S. The readback is (stored & W) | (status byte & S), and a write stores data & W. The values of W/S per address are:

  | Address | W/S |
  |---|---|
  | 0x00 | C1/3E |
  | 0x01 | FF/00 |
  | 0x02 | BF/00 |
  | 0x03 | 80/0F |
  | 0x04 | 80/07 |
  | 0x05 | E0/0C |
  | 0x06 | 3F/00 |
  | 0x07 | 0F/90 |
  | 0x08 | FF/00 |
  | 0x09 | FF/00 |
  | 0x0A | 00/EF |
  | 0x0B | E0/00 |
  | 0x0C | 00/FF |
  | 0x0D | 00/FF |
  | 0x0E | 00/00 |

  The status byte for address n is `stat_in[8n+7:8n]`.
- R10: `spi_miso_oe` is low and `spi_miso` is 0 while select is high.
- R11: After reset every stored register bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idles low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| stat_in | input | NREG*8 | Read-only status bits, one byte per address |
| ctrl_q | output | NREG*8 | Stored register contents, one byte per address |

## Verification
The bench builds the block with its defaults: eighteen registers and a two-stage synchroniser. The serial clock half-period is eight system clocks, so every synchronised edge settles well before the host samples. With all eighteen addresses present, the bench can reach every address class: the write-only trim range, the protected test address, addresses above the implemented range, and read-only bits mixed with writable bits. The bench varies the frame length across 12, 16 and 17 edges, which exercises each state of the machine, including S_OVER. It also changes the status inputs mid-run, so the live status byte is compared and not a constant.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
    localparam int DW        = 8;
    localparam int AW        = 5;
    localparam int FRAME     = 2 * DW;
    localparam int STAT_ADDR = 12;
    localparam int TEST_ADDR = 14;
    localparam int WO_FIRST  = 15;
    localparam int WO_LAST   = 17;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_DATA,
        S_FULL,
        S_OVER
    } frame_state_t;

    function automatic logic [DW-1:0] wr_mask(input int a);
        case (a)
            0:  return 8'hC1;
            1:  return 8'hFF;
            2:  return 8'hBF;
            3:  return 8'h80;
            4:  return 8'h80;
            5:  return 8'hE0;
            6:  return 8'h3F;
            7:  return 8'h0F;
            8:  return 8'hFF;
            9:  return 8'hFF;
            11: return 8'hE0;
            15, 16, 17: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [DW-1:0] ro_mask(input int a);
        case (a)
            0:  return 8'h3E;
            3:  return 8'h0F;
            4:  return 8'h07;
            5:  return 8'h0C;
            7:  return 8'h90;
            10: return 8'hEF;
            12, 13: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic is_write_only(input int a);
        return (a >= WO_FIRST) && (a <= WO_LAST);
    endfunction
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic mosi_s
);
    logic [STAGES:0]   sck_p;
    logic [STAGES:0]   cs_p;
    logic [STAGES-1:0] mosi_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p  <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
        end else begin
            sck_p  <= {sck_p[STAGES-1:0], sck};
            cs_p   <= {cs_p[STAGES-1:0], cs_n};
            mosi_p <= {mosi_p[STAGES-2:0], mosi};
        end
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
    assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
    assign cs_fall  = ~cs_p[STAGES-1] & cs_p[STAGES];
    assign cs_rise  = cs_p[STAGES-1] & ~cs_p[STAGES];
    assign mosi_s   = mosi_p[STAGES-1];
endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
    import spi_rf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          mosi_s,
    input  logic [DW-1:0] stat_byte,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [DW-1:0] wr_cmd,
    output logic          miso,
    output logic          miso_oe,
    output frame_state_t  state
);
    localparam int CW = $clog2(FRAME + 1);

    frame_state_t   state_nx;
    logic [CW-1:0]  bit_cnt;
    logic [FRAME-1:0] rx_sh;
    logic [DW-1:0]  tx_sh;
    logic           shifting;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (cs_fall) state_nx = S_CMD;
            S_CMD: begin
                if (cs_rise) state_nx = S_IDLE;
                else if (sck_rise && bit_cnt == CW'(DW - 1)) state_nx = S_DATA;
            end
            S_DATA: begin
                if (cs_rise) state_nx = S_IDLE;
                else if (sck_rise && bit_cnt == CW'(FRAME - 1)) state_nx = S_FULL;
            end
            S_FULL: begin
                if (cs_rise) state_nx = S_IDLE;
                else if (sck_rise) state_nx = S_OVER;
            end
            S_OVER: if (cs_rise) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    assign shifting = (state == S_CMD) || (state == S_DATA);

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
        end else if (state == S_IDLE) begin
            bit_cnt <= '0;
            if (cs_fall) tx_sh <= stat_byte;
        end else begin
            if (sck_rise && shifting) begin
                rx_sh   <= {rx_sh[FRAME-2:0], mosi_s};
                bit_cnt <= bit_cnt + CW'(1);
            end
            if (sck_fall) begin
                if (bit_cnt == CW'(DW)) tx_sh <= rd_data;
                else                    tx_sh <= {tx_sh[DW-2:0], 1'b0};
            end
        end
    end

    assign rd_addr = rx_sh[DW-1 -: AW];
    assign wr_cmd  = rx_sh[FRAME-1 -: DW];
    assign wr_addr = rx_sh[FRAME-1 -: AW];
    assign wr_data = rx_sh[DW-1:0];

    // outputs
    always_comb begin
        miso_oe = (state != S_IDLE);
        miso    = miso_oe & tx_sh[DW-1];
        wr_en   = cs_rise && (state == S_FULL) && !wr_cmd[1]
                  && (^(wr_cmd & 8'hFB));
    end
endmodule

// File: rtl/spi_rf_regs.sv
module spi_rf_regs
    import spi_rf_pkg::*;
#(
    parameter int NREG = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    stat_byte,
    input  logic [NREG*DW-1:0] stat_in,
    output logic [NREG*DW-1:0] ctrl_q
);
    logic [DW-1:0] regs_q  [NREG];
    logic [DW-1:0] rb_arr  [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DW-1:0] WM = wr_mask(i);
        localparam logic [DW-1:0] RM = ro_mask(i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (wr_en && wr_addr == AW'(i))
                regs_q[i] <= wr_data & WM;
        end

        if (is_write_only(i)) begin : g_wo
            assign rb_arr[i] = '0;
        end else begin : g_rw
            assign rb_arr[i] = (regs_q[i] & WM) | (stat_in[i*DW +: DW] & RM);
        end

        assign ctrl_q[i*DW +: DW] = regs_q[i];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_addr == AW'(i)) rd_data = rb_arr[i];
    end

    assign stat_byte = rb_arr[STAT_ADDR];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_rf_pkg::*;
#(
    parameter int NREG        = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sck,
    input  logic               spi_cs_n,
    input  logic               spi_mosi,
    output logic               spi_miso,
    output logic               spi_miso_oe,
    input  logic [NREG*DW-1:0] stat_in,
    output logic [NREG*DW-1:0] ctrl_q
);
    logic          sck_rise, sck_fall, cs_fall, cs_rise, mosi_s;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, stat_byte, wr_data, wr_cmd;
    logic          wr_en;
    frame_state_t  frame_state;

    spi_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .mosi_s   (mosi_s)
    );

    spi_rf_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .mosi_s    (mosi_s),
        .stat_byte (stat_byte),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_cmd    (wr_cmd),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe),
        .state     (frame_state)
    );

    spi_rf_regs #(.NREG(NREG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .stat_byte (stat_byte),
        .stat_in   (stat_in),
        .ctrl_q    (ctrl_q)
    );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
    import spi_rf_pkg::*;
#(
    parameter int NREG = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sck_rise,
    input logic               cs_fall,
    input logic               cs_rise,
    input logic               wr_en,
    input logic [DW-1:0]      wr_cmd,
    input logic [AW-1:0]      rd_addr,
    input logic [DW-1:0]      rd_data,
    input logic               spi_miso_oe,
    input logic               spi_miso,
    input logic [NREG*DW-1:0] ctrl_q
);
    logic [5:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          rise_cnt <= '0;
        else if (cs_fall)                    rise_cnt <= '0;
        else if (sck_rise && rise_cnt != 6'h3F) rise_cnt <= rise_cnt + 6'd1;
    end

    a_r6_commit_needs_16: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rise_cnt == 6'(FRAME));

    a_r5_commit_parity_odd: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!wr_cmd[1] && (^{wr_cmd[7:3], wr_cmd[1:0]})));

    a_r4_stable_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));

    a_r10_oe_drops_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (!spi_miso_oe && !spi_miso));

    a_r8_test_reg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[TEST_ADDR*DW +: DW] == '0);

    a_r7_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr >= AW'(WO_FIRST)) |-> rd_data == '0);
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.NREG(NREG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_rise    (sck_rise),
    .cs_fall     (cs_fall),
    .cs_rise     (cs_rise),
    .wr_en       (wr_en),
    .wr_cmd      (wr_cmd),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .spi_miso_oe (spi_miso_oe),
    .spi_miso    (spi_miso),
    .ctrl_q      (ctrl_q)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;
    localparam int NREG = 18;
    localparam int HALF = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic spi_sck = 0, spi_cs_n = 1, spi_mosi = 0;
    logic spi_miso, spi_miso_oe;
    logic [NREG*8-1:0] stat_in;
    logic [NREG*8-1:0] ctrl_q;

    int n_checks = 0;
    int n_fail = 0;
    int cs_high_cnt = 0;
    logic [7:0] model [NREG];

    always #5 clk = ~clk;

    spi_reg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .stat_in(stat_in), .ctrl_q(ctrl_q)
    );

    task automatic chk(input logic ok, input string req, input logic [NREG*8-1:0] act,
                       input logic [NREG*8-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R1/R9: bench-side mask table
    function automatic logic [7:0] wm(input int a);
        case (a)
            0: return 8'hC1; 1: return 8'hFF; 2: return 8'hBF; 3: return 8'h80;
            4: return 8'h80; 5: return 8'hE0; 6: return 8'h3F; 7: return 8'h0F;
            8: return 8'hFF; 9: return 8'hFF; 11: return 8'hE0;
            15, 16, 17: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] sm(input int a);
        case (a)
            0: return 8'h3E; 3: return 8'h0F; 4: return 8'h07; 5: return 8'h0C;
            7: return 8'h90; 10: return 8'hEF; 12, 13: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] rb(input int a);
        if (a >= 15) return 8'h00;
        return (model[a] & wm(a)) | (stat_in[a*8 +: 8] & sm(a));
    endfunction

    function automatic logic [NREG*8-1:0] model_vec();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    function automatic logic [7:0] mk_cmd(input int addr, input logic rd, input logic good);
        logic p;
        p = ~^{addr[4:0], rd};
        if (!good) p = ~p;
        return {addr[4:0], 1'b0, rd, p};
    endfunction

    task automatic xfer(input logic [7:0] cmd, input logic [7:0] dat, input int nbits,
                        input string req);
        logic [15:0] word;
        logic [15:0] rep;
        logic [15:0] exp;
        int a;
        word = {cmd, dat};
        rep = '0;
        a = int'(cmd[7:3]);
        exp = {rb(12), rb(a)};
        @(negedge clk);
        spi_cs_n = 0;
        for (int b = 0; b < nbits; b++) begin
            spi_mosi = (b < 16) ? word[15-b] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (b < 16) rep[15-b] = spi_miso;
            spi_sck = 1;
            repeat (HALF) @(negedge clk);
            spi_sck = 0;
        end
        repeat (HALF) @(negedge clk);
        chk(ctrl_q == model_vec(), {req, " R4 pre-select-rise"}, ctrl_q, model_vec());
        if (nbits >= 16) begin
            chk(rep[15:8] == exp[15:8], {req, " R2 status byte"}, rep[15:8], exp[15:8]);
            chk(rep[7:0] == exp[7:0], {req, " R3 data byte"}, rep[7:0], exp[7:0]);
        end
        spi_cs_n = 1;
        if (nbits == 16 && !cmd[1] && (^{cmd[7:3], cmd[1:0]}) && a < NREG)
            model[a] = dat & wm(a);
        repeat (8) @(negedge clk);
        chk(ctrl_q == model_vec(), {req, " R4 post-commit"}, ctrl_q, model_vec());
    endtask

    // R10: checked on every clock once select has been high a few cycles
    always @(negedge clk) begin
        if (!spi_cs_n) cs_high_cnt <= 0;
        else           cs_high_cnt <= cs_high_cnt + 1;
        if (rst_n && spi_cs_n && cs_high_cnt >= 4)
            chk(!spi_miso_oe && !spi_miso, "R10 idle output", {spi_miso_oe, spi_miso}, 0);
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin
            model[i] = 8'h00;
            stat_in[i*8 +: 8] = 8'h5A ^ 8'(i * 19);
        end
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk(ctrl_q == '0, "R11 reset registers", ctrl_q, '0);
        chk(!spi_miso_oe && !spi_miso, "R10 reset outputs", {spi_miso_oe, spi_miso}, 0);

        xfer(mk_cmd(12, 1, 1), 8'h00, 16, "R2 read status");
        xfer(mk_cmd(1, 0, 1), 8'hA5, 16, "R3 first write");
        xfer(mk_cmd(1, 0, 1), 8'h3C, 16, "R3 prewrite reply");
        xfer(mk_cmd(1, 1, 1), 8'hFF, 16, "R1 read back");
        xfer(mk_cmd(8, 0, 0), 8'h55, 16, "R5 bad parity write");
        xfer(mk_cmd(8, 1, 1), 8'h00, 16, "R5 bad parity check");
        xfer(mk_cmd(1, 1, 0), 8'h00, 16, "R5 parity ignored on read");
        xfer(mk_cmd(0, 0, 1), 8'hFF, 16, "R9 mixed bits write");
        xfer(mk_cmd(0, 1, 1), 8'h00, 16, "R9 mixed bits read");
        xfer(mk_cmd(7, 0, 1), 8'hFF, 16, "R9 partial mask write");
        xfer(mk_cmd(14, 0, 1), 8'hFF, 16, "R8 test reg write");
        xfer(mk_cmd(14, 1, 1), 8'h00, 16, "R8 test reg read");
        xfer(mk_cmd(15, 0, 1), 8'h5A, 16, "R7 trim write");
        xfer(mk_cmd(17, 0, 1), 8'hA3, 16, "R7 trim write high");
        xfer(mk_cmd(15, 1, 1), 8'h00, 16, "R7 trim read zero");
        xfer(mk_cmd(19, 0, 1), 8'h77, 16, "R8 unimplemented write");
        xfer(mk_cmd(19, 1, 1), 8'h00, 16, "R8 unimplemented read");
        xfer(mk_cmd(9, 0, 1), 8'h11, 12, "R6 short frame");
        xfer(mk_cmd(9, 0, 1), 8'h22, 17, "R6 long frame");
        xfer(mk_cmd(9, 1, 1), 8'h00, 16, "R6 after bad lengths");
        xfer(mk_cmd(9, 0, 1), 8'h77, 16, "R6 exact frame");
        for (int i = 0; i < NREG; i++) stat_in[i*8 +: 8] = 8'hC3 ^ 8'(i * 7);
        xfer(mk_cmd(10, 1, 1), 8'h00, 16, "R2 new status");
        xfer(mk_cmd(9, 1, 1), 8'h00, 16, "R3 final read");

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule